// File: doc/BRIEF.md
# Shadow Memory Attribute Decoder

This block sits in a host bridge and decides where each access into the upper part of the first megabyte lands. It looks at the address and at the direction of the access. The result is one of three targets: local DRAM, the expansion bus, or "not handled" for addresses this block does not cover.

A set of byte-wide configuration registers shapes the decision. Seven attribute registers hold 2-bit codes for the twelve 16 KB option-ROM segments from 0xC0000 to 0xEFFFF and for the 64 KB region from 0xF0000 to 0xFFFFF. A system-management RAM control register decides the legacy video window from 0xA0000 to 0xBFFFF. It can open that window to DRAM for good, or only while the system-management mode input is high. A memory-size register holds the installed memory in 8 MB units. Its reset value comes from a parameter.

Firmware uses the attribute codes to copy ROM into DRAM and then run it from there. The steps are: reads go to the bus, then writes go to DRAM, then the region is made read-only. The decode is reworked on every clock from the present register contents and the present SMM level. A configuration write or an SMM change therefore takes effect on the very next request.

Top module: `shadow_attr_decoder`

## Requirements
- R1: After a synchronous reset, every attribute register (offsets 0x59 to 0x5F) reads 0x00 and the SMRAM control register (offset 0x72) reads 0x02. Every address from 0xC0000 to 0xFFFFF then selects the bus.
- R2: A write to offset 0x57, 0x59 to 0x5F or 0x72 stores the full byte. `cfg_rdata` shows the byte at `cfg_addr` one cycle later, as it was before any write in that same cycle. All other offsets read 0x00 and ignore writes.
- R3: Addresses 0xF0000 to 0xFFFFF use the attribute code in bits 5:4 of offset 0x59.
- R4: Segment i = (addr - 0xC0000) / 16384, for i from 0 to 11, uses offset 0x5A + i/2. Bits 1:0 of that byte hold the code for even i, and bits 5:4 hold it for odd i. The other bits of each nibble do not matter.
- R5: Code 3 selects DRAM for reads and writes. Code 1 selects DRAM for reads and the bus for writes. Codes 0 and 2 select the bus.
- R6: Addresses 0xA0000 to 0xBFFFF select DRAM when bit 6 of offset 0x72 is set. They also select DRAM when bit 3 is set and `smm_active` is high. Otherwise they select the bus.
- R7: Addresses below 0xA0000 always select DRAM. Addresses at or above 0x100000 select "not handled".
- R8: `tgt_valid` and `tgt_sel` are registered, one cycle after the request. When `req_valid` is low, `tgt_valid` is 0 and `tgt_sel` is "not handled". The encodings are: 0 = not handled, 1 = DRAM, 2 = bus. The decode always uses the register contents and the `smm_active` level that are present in the request cycle.
- R9: Offset 0x57 resets to MEM_MB/8, saturated at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset (write and read) |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Registered read data for `cfg_addr` |
| smm_active | input | 1 | System-management mode active level |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_addr | input | ADDR_W | Access physical address |
| tgt_valid | output | 1 | Registered: decode result valid |
| tgt_sel | output | 2 | Registered target: 0 none, 1 DRAM, 2 bus |

## Verification
The assertions assume that `req_addr`, `req_write` and `smm_active` do not change within a clock cycle. They also assume that the inputs are never unknown while reset is low. The bench drives every input at the falling edge from initial-block tasks, so that assumption holds.

The assertions about the video window check against the SMRAM control byte as it stood during the request cycle. The bench keeps to this by applying configuration writes at the same edge the model uses. The random phase mixes writes, SMM toggles and requests within a cycle, and every mix is one the model treats the same way.

// File: rtl/sad_pkg.sv
package sad_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_DRAM = 2'd1,
    TGT_BUS  = 2'd2
  } tgt_e;

  localparam logic [1:0] CODE_RW = 2'd3;
  localparam logic [1:0] CODE_RO = 2'd1;

  localparam logic [7:0] OFF_MEMSZ = 8'h57;
  localparam logic [7:0] OFF_ATTR  = 8'h59;
  localparam logic [7:0] OFF_SMRAM = 8'h72;
  localparam logic [7:0] SMRAM_RST = 8'h02;
  localparam int SMRAM_OPEN_BIT = 6;
  localparam int SMRAM_SMM_BIT  = 3;

  localparam int LOW_TOP = 32'h000A_0000;
  localparam int VID_TOP = 32'h000C_0000;
  localparam int MEM_TOP = 32'h0010_0000;
endpackage

// File: rtl/sad_cfg_regs.sv
module sad_cfg_regs
  import sad_pkg::*;
#(
  parameter int NATTR  = 7,
  parameter int MEM_MB = 128
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [7:0]            cfg_addr,
  input  logic [7:0]            cfg_wdata,
  output logic [7:0]            cfg_rdata,
  output logic [NATTR-1:0][7:0] attr_q,
  output logic [7:0]            smram_q
);
  localparam int MEMSZ_RAW = MEM_MB / 8;
  localparam logic [7:0] MEMSZ_RST = (MEMSZ_RAW > 255) ? 8'hFF : 8'(MEMSZ_RAW);

  logic [7:0] memsz_q;
  logic [7:0] rd_mux;

  genvar k;
  generate
    for (k = 0; k < NATTR; k++) begin : g_attr
      localparam logic [7:0] MY_OFF = OFF_ATTR + 8'(k);
      always_ff @(posedge clk) begin
        if (rst) attr_q[k] <= 8'h00;
        else if (cfg_we && cfg_addr == MY_OFF) attr_q[k] <= cfg_wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      smram_q <= SMRAM_RST;
      memsz_q <= MEMSZ_RST;
    end else if (cfg_we) begin
      if (cfg_addr == OFF_SMRAM) smram_q <= cfg_wdata;
      if (cfg_addr == OFF_MEMSZ) memsz_q <= cfg_wdata;
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    if (cfg_addr == OFF_SMRAM) rd_mux = smram_q;
    if (cfg_addr == OFF_MEMSZ) rd_mux = memsz_q;
    for (int j = 0; j < NATTR; j++)
      if (cfg_addr == OFF_ATTR + 8'(j)) rd_mux = attr_q[j];
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= 8'h00;
    else     cfg_rdata <= rd_mux;
  end
endmodule

// File: rtl/sad_region_decode.sv
module sad_region_decode
  import sad_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int N_SEG     = 12,
  parameter int SEG_SHIFT = 14,
  parameter int NATTR     = 1 + N_SEG / 2
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  is_write,
  input  logic                  smm,
  input  logic [NATTR-1:0][7:0] attr_q,
  input  logic [7:0]            smram_q,
  output tgt_e                  tgt
);
  localparam int HI_BASE   = VID_TOP + N_SEG * (1 << SEG_SHIFT);
  localparam int SEG_IDX_W = $clog2(N_SEG);

  logic [N_SEG-1:0][1:0] seg_code;
  logic [ADDR_W-1:0]     seg_off;
  logic [SEG_IDX_W-1:0]  seg_idx;
  logic [1:0]            code;
  logic                  in_attr;

  genvar s;
  generate
    for (s = 0; s < N_SEG; s++) begin : g_seg
      if (s % 2 == 0) begin : g_lo
        assign seg_code[s] = attr_q[1 + s / 2][1:0];
      end else begin : g_hi
        assign seg_code[s] = attr_q[1 + s / 2][5:4];
      end
    end
  endgenerate

  assign seg_off = addr - ADDR_W'(VID_TOP);
  assign seg_idx = seg_off[SEG_SHIFT +: SEG_IDX_W];

  always_comb begin
    code    = 2'd0;
    in_attr = 1'b0;
    if (addr >= ADDR_W'(VID_TOP) && addr < ADDR_W'(MEM_TOP)) begin
      in_attr = 1'b1;
      if (addr >= ADDR_W'(HI_BASE)) code = attr_q[0][5:4];
      else                          code = seg_code[seg_idx];
    end
  end

  always_comb begin
    if (addr >= ADDR_W'(MEM_TOP)) begin
      tgt = TGT_NONE;
    end else if (addr < ADDR_W'(LOW_TOP)) begin
      tgt = TGT_DRAM;
    end else if (!in_attr) begin
      tgt = (smram_q[SMRAM_OPEN_BIT] || (smram_q[SMRAM_SMM_BIT] && smm))
            ? TGT_DRAM : TGT_BUS;
    end else begin
      case (code)
        CODE_RW: tgt = TGT_DRAM;
        CODE_RO: tgt = is_write ? TGT_BUS : TGT_DRAM;
        default: tgt = TGT_BUS;
      endcase
    end
  end
endmodule

// File: rtl/sad_out_reg.sv
module sad_out_reg
  import sad_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  tgt_e tgt_d,
  output logic tgt_valid,
  output logic [1:0] tgt_sel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_valid <= 1'b0;
      tgt_sel   <= TGT_NONE;
    end else begin
      tgt_valid <= req_valid;
      tgt_sel   <= req_valid ? tgt_d : TGT_NONE;
    end
  end
endmodule

// File: rtl/shadow_attr_decoder.sv
module shadow_attr_decoder
  import sad_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int N_SEG     = 12,
  parameter int SEG_SHIFT = 14,
  parameter int MEM_MB    = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              smm_active,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              tgt_valid,
  output logic [1:0]        tgt_sel
);
  localparam int NATTR = 1 + N_SEG / 2;

  logic [NATTR-1:0][7:0] attr_q;
  logic [7:0]            smram_q;
  tgt_e                  tgt_d;

  sad_cfg_regs #(.NATTR(NATTR), .MEM_MB(MEM_MB)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .attr_q(attr_q), .smram_q(smram_q)
  );

  sad_region_decode #(.ADDR_W(ADDR_W), .N_SEG(N_SEG), .SEG_SHIFT(SEG_SHIFT),
                      .NATTR(NATTR)) u_dec (
    .addr(req_addr), .is_write(req_write), .smm(smm_active),
    .attr_q(attr_q), .smram_q(smram_q), .tgt(tgt_d)
  );

  sad_out_reg u_out (
    .clk(clk), .rst(rst), .req_valid(req_valid), .tgt_d(tgt_d),
    .tgt_valid(tgt_valid), .tgt_sel(tgt_sel)
  );
endmodule

// File: rtl/sad_checker.sv
module sad_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              smm_active,
  input logic [7:0]        smram_q,
  input logic              tgt_valid,
  input logic [1:0]        tgt_sel
);
  localparam logic [ADDR_W-1:0] A_LOW = ADDR_W'(32'h000A_0000);
  localparam logic [ADDR_W-1:0] A_VID = ADDR_W'(32'h000C_0000);
  localparam logic [ADDR_W-1:0] A_TOP = ADDR_W'(32'h0010_0000);

  logic in_vid;
  assign in_vid = req_addr >= A_LOW && req_addr < A_VID;

  assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> tgt_valid);

  assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!tgt_valid && tgt_sel == 2'd0));

  assert_low_dram_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr < A_LOW) |=> tgt_sel == 2'd1);

  assert_high_none_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr >= A_TOP) |=> tgt_sel == 2'd0);

  assert_video_open_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && in_vid && (smram_q[6] || (smram_q[3] && smm_active)))
      |=> tgt_sel == 2'd1);

  assert_video_closed_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && in_vid && !smram_q[6] && !(smram_q[3] && smm_active))
      |=> tgt_sel == 2'd2);
endmodule

bind shadow_attr_decoder sad_checker #(.ADDR_W(ADDR_W)) u_sad_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .smm_active(smm_active), .smram_q(smram_q),
  .tgt_valid(tgt_valid), .tgt_sel(tgt_sel)
);

// File: tb/tb_shadow_attr_decoder.sv
`timescale 1ns/1ps
module tb_shadow_attr_decoder;
  localparam int MEM_MB = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = 8'h00;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic smm_active = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [31:0] req_addr = 32'h0;
  logic tgt_valid;
  logic [1:0] tgt_sel;

  always #4 clk = ~clk;

  shadow_attr_decoder #(.MEM_MB(MEM_MB)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .smm_active(smm_active),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .tgt_valid(tgt_valid), .tgt_sel(tgt_sel)
  );

  int checks = 0;
  int failures = 0;
  bit chk_en = 0;

  // behavioural reference model
  int m [256];
  int exp_rdata, exp_sel, exp_valid;
  string exp_tag;

  function automatic int memsz_rst();
    return (MEM_MB / 8 > 255) ? 255 : MEM_MB / 8;  // R9
  endfunction

  function automatic bit mapped(int off);
    return off == 'h57 || off == 'h72 || (off >= 'h59 && off <= 'h5F);
  endfunction

  function automatic string tag_of(longint a);
    if (a >= 'h100000 || a < 'hA0000) return "R7";
    if (a < 'hC0000) return "R6";
    if (a >= 'hF0000) return "R3";
    return "R4";
  endfunction

  function automatic int model_tgt(longint a, bit w, bit smm);
    int code, seg, b;
    if (a >= 'h100000) return 0;
    if (a < 'hA0000) return 1;
    if (a < 'hC0000) return ((m['h72] & 'h40) != 0 || ((m['h72] & 'h08) != 0 && smm)) ? 1 : 2;
    if (a >= 'hF0000) code = (m['h59] >> 4) & 3;
    else begin
      seg = int'((a - 'hC0000) / 16384);
      b = m['h5A + seg / 2];
      code = ((seg % 2) != 0) ? (b >> 4) & 3 : b & 3;
    end
    if (code == 3) return 1;             // R5
    if (code == 1) return w ? 2 : 1;     // R5
    return 2;                            // R5
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) m[i] = 0;
      m['h72] = 'h02;
      m['h57] = memsz_rst();
      exp_valid = 0; exp_sel = 0; exp_rdata = 0; exp_tag = "R1";
    end else begin
      exp_valid = req_valid;
      exp_sel = req_valid ? model_tgt(longint'(req_addr), req_write, smm_active) : 0;
      exp_tag = req_valid ? tag_of(longint'(req_addr)) : "R8";
      exp_rdata = m[cfg_addr];
      if (cfg_we && mapped(cfg_addr)) m[cfg_addr] = cfg_wdata;
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      checks++;
      if (tgt_valid !== exp_valid[0] || tgt_sel !== exp_sel[1:0]) begin
        failures++;
        $display("FAIL %s/R8 target: got valid=%0b sel=%0d expected valid=%0d sel=%0d",
                 exp_tag, tgt_valid, tgt_sel, exp_valid, exp_sel);
      end
      checks++;
      if (cfg_rdata !== exp_rdata[7:0]) begin
        failures++;
        $display("FAIL R2 rdata: got %02h expected %02h", cfg_rdata, exp_rdata[7:0]);
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(int off, int val);
    cfg_we = 1; cfg_addr = 8'(off); cfg_wdata = 8'(val);
    req_valid = 0;
    step();
    cfg_we = 0;
  endtask

  task automatic acc(longint a, bit w);
    req_valid = 1; req_write = w; req_addr = 32'(a);
    step();
    req_valid = 0;
  endtask

  task automatic sweep();
    for (longint a = 'h9F000; a <= 'h101000; a += 'h1000) begin
      acc(a, 0);
      acc(a + 'h3FF, 1);
    end
  endtask

  // R1 and R9: explicit reset-state read checks on top of the per-clock compare
  task automatic chk_reset_reg(int off, int val, string tag);
    cfg_addr = 8'(off);
    step();
    step();
    checks++;
    if (cfg_rdata !== 8'(val)) begin
      failures++;
      $display("FAIL %s reset value @%02h: got %02h expected %02h", tag, off, cfg_rdata, 8'(val));
    end
  endtask

  initial begin
    repeat (4) step();
    rst = 0;
    chk_en = 1;
    chk_reset_reg('h72, 'h02, "R1");
    chk_reset_reg('h57, memsz_rst(), "R9");
    for (int o = 'h59; o <= 'h5F; o++) chk_reset_reg(o, 0, "R1");
    for (int o = 0; o < 256; o++) begin cfg_addr = 8'(o); step(); end  // R2 read sweep
    sweep();                                                          // R1 all-bus state
    // R3 R4 R5: assorted codes, upper nibble bits set to show they are ignored
    wr('h59, 'h3C); wr('h5A, 'h31); wr('h5B, 'h1E); wr('h5C, 'h20);
    wr('h5D, 'hC3); wr('h5E, 'h10); wr('h5F, 'hFF);
    sweep();
    wr('h59, 'h10); wr('h5A, 'h13); wr('h5F, 'h02);
    sweep();
    // R6: SMM-gated window then forced-open window
    wr('h72, 'h08);
    smm_active = 0; sweep();
    smm_active = 1; sweep();
    wr('h72, 'h40); smm_active = 0; sweep();
    wr('h72, 'h00); smm_active = 1; sweep();
    // R2: unmapped offsets ignore writes
    wr('h58, 'hFF); wr('h60, 'hAA); wr('h71, 'h55); wr('h00, 'h11);
    for (int o = 'h56; o <= 'h73; o++) begin cfg_addr = 8'(o); step(); end
    wr('h57, 'h7E);
    // R8: writes and SMM changes take effect on the next request, random mix
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom_range(0, 9));
      cfg_we = (r < 3);
      cfg_addr = (r < 2) ? 8'('h59 + $urandom_range(0, 6)) :
                 (r == 2) ? 8'h72 : 8'($urandom_range(0, 255));
      cfg_wdata = 8'($urandom);
      smm_active = ($urandom_range(0, 3) == 0) ? ~smm_active : smm_active;
      req_valid = ($urandom_range(0, 4) != 0);
      req_write = 1'($urandom);
      req_addr = ($urandom_range(0, 7) == 0) ? $urandom_range(0, 32'h0012_0000)
                                             : 32'h0009_8000 + $urandom_range(0, 32'h0006_9000);
      step();
    end
    cfg_we = 0; req_valid = 0;
    step(); step();
    chk_en = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    failures++;
    checks++;
    $display("FAIL watchdog expired: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule